// File: doc/BRIEF.md
# Ethernet MAC Transmit Byte Sequencer

This block runs the transmit side of a 10 Mbit/s MAC, clocked by the bit-rate transmit clock. It advances one bit per clock. After a start request it sends the framing preamble and the start-of-frame delimiter. It then fetches payload bytes from the host one at a time through a one-clock load strobe and sends each byte least-significant bit first on a single serial data line.

The host ends the payload with a one-clock end-of-data pulse, given while the last byte is going out. The block can then append the 32-bit frame check sequence. It can also append that sequence bit-inverted, which produces a frame that receivers will reject. A third choice is to end the frame right after the payload. A one-clock pulse marks each byte put on the line, and a one-clock end-of-packet pulse marks completion. Collision handling, backoff and line coding sit in neighbouring blocks.

Top module: `eth_tx_byte_seq`

## Requirements
- R1: While reset is asserted and afterwards until a request, tx_en_o, txd_o, load_o, byte_o and eop_o are all 0.
- R2: A tx_req_i pulse in idle starts a frame. From the next clock, tx_en_o is 1 and txd_o carries seven 0x55 bytes and then 0xD5, which is 64 bits, each byte least-significant bit first.
- R3: The first load_o pulse falls in the clock that carries the 64th preamble bit. The byte on tx_data_i in that clock is captured at the clock's end, and its bits follow at once, least-significant bit first.
- R4: Each later load_o pulse comes exactly 8 clocks after the previous one. The byte present during each pulse is sent next.
- R5: A one-clock tx_eod_i pulse in any of the 8 clocks that carry a payload byte, including that byte's last bit clock, makes that byte the last one. No load_o pulse follows it.
- R6: With crc_en_i high at the request, the last payload bit is followed by 32 check bits. These are the complement of the CRC-32 (polynomial 0x04C11DB7, reflected, register preset to all ones) over the payload, sent least-significant bit first. The payload "123456789" yields check value 0xCBF43926.
- R7: With crc_en_i and crc_inv_i both high at the request, the 32 check bits are the bitwise inverse of those in R6.
- R8: With crc_en_i low at the request, tx_en_o drops right after the last payload bit. Mode inputs that change after the request do not alter the frame.
- R9: byte_o pulses for one clock in the last bit clock of every payload and check byte, and never during the preamble. An N-byte frame gives N+4 pulses with the check sequence and N pulses without it.
- R10: eop_o is a single one-clock pulse in the first clock in which tx_en_o is low again after a frame.
- R11: A tx_req_i pulse while a frame is in progress is ignored. It neither restarts nor extends the frame.
- R12: tx_en_o stays high without a gap from the first preamble bit through the last bit of the frame, and txd_o is 0 whenever tx_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_req_i | input | 1 | Start-of-frame request pulse |
| tx_data_i | input | 8 | Payload byte, valid while load_o is high |
| tx_eod_i | input | 1 | One-clock end-of-data marker |
| crc_en_i | input | 1 | Append the check sequence (sampled at request) |
| crc_inv_i | input | 1 | Invert the appended check sequence (sampled at request) |
| tx_en_o | output | 1 | Frame on the line |
| txd_o | output | 1 | Serial transmit data |
| load_o | output | 1 | One-clock byte fetch strobe |
| byte_o | output | 1 | One-clock pulse per payload or check byte sent |
| eop_o | output | 1 | One-clock end-of-packet pulse |

## Verification
The assertions check on every cycle the fixed 8-clock spacing of fetch strobes within a frame, the absence of any strobe after end-of-data, the single eop_o pulse where tx_en_o falls, and the quiet line outside a frame. Only the bench scenarios can show the bit content of the line. That covers the preamble pattern, the placement of captured bytes, the check sequence value and its inverted form, byte-pulse totals, and the insensitivity to late mode changes and to requests made mid-frame, because each needs a reference frame computed from the payload.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_FCS,
    ST_END
  } tx_state_e;

  localparam int          BYTE_W    = 8;
  localparam int          CRC_W     = 32;
  localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
  localparam logic [7:0]  PRE_BYTE  = 8'h55;
  localparam logic [7:0]  SFD_BYTE  = 8'hD5;
  localparam int          PRE_BYTES = 8;
endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc #(
  parameter int             W    = 32,
  parameter logic [W-1:0]   POLY = 32'h04C1_1DB7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic drain_i,
  output logic msb_o
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  always_comb begin
    fb    = crc_q[W-1] ^ bit_i;
    crc_d = crc_q;
    if (init_i)
      crc_d = '1;
    else if (upd_i)
      crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (drain_i)
      crc_d = {crc_q[W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  assign msb_o = crc_q[W-1];
endmodule

// File: rtl/eth_tx_bitcnt.sv
module eth_tx_bitcnt #(
  parameter int BPB  = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            clr_idx_i,
  output logic            last_bit_o,
  output logic [IDXW-1:0] byte_idx_o
);
  localparam int BW = $clog2(BPB);
  localparam logic [BW-1:0] BIT_LAST = BW'(BPB - 1);

  logic [BW-1:0]   bit_q, bit_d;
  logic [IDXW-1:0] idx_q, idx_d;

  assign last_bit_o = run_i && (bit_q == BIT_LAST);
  assign byte_idx_o = idx_q;

  always_comb begin
    bit_d = '0;
    if (run_i) bit_d = last_bit_o ? '0 : bit_q + 1'b1;
    idx_d = idx_q;
    if (clr_idx_i)       idx_d = '0;
    else if (last_bit_o) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      idx_q <= '0;
    end else begin
      bit_q <= bit_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/eth_tx_byte_seq.sv
module eth_tx_byte_seq
  import eth_tx_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_req_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_eod_i,
  input  logic          crc_en_i,
  input  logic          crc_inv_i,
  output logic          tx_en_o,
  output logic          txd_o,
  output logic          load_o,
  output logic          byte_o,
  output logic          eop_o
);
  localparam int IDXW = $clog2(PRE_BYTES);
  localparam int FCS_BYTES = CRC_W / DW;
  localparam logic [IDXW-1:0] IDX_SFD  = IDXW'(PRE_BYTES - 1);
  localparam logic [IDXW-1:0] IDX_LPRE = IDXW'(PRE_BYTES - 2);
  localparam logic [IDXW-1:0] IDX_LFCS = IDXW'(FCS_BYTES - 1);

  tx_state_e       state_q, state_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic            eod_seen_q, eod_seen_d;
  logic            fcs_en_q, fcs_en_d;
  logic            fcs_inv_q, fcs_inv_d;
  logic            run, clr_idx, last_bit, eod_now, crc_msb;
  logic [IDXW-1:0] idx;

  eth_tx_bitcnt #(.BPB(DW), .IDXW(IDXW)) i_bitcnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .clr_idx_i  (clr_idx),
    .last_bit_o (last_bit),
    .byte_idx_o (idx)
  );

  eth_tx_crc #(.W(CRC_W), .POLY(CRC_POLY)) i_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_i  (state_q == ST_IDLE),
    .upd_i   (state_q == ST_DATA),
    .bit_i   (sh_q[0]),
    .drain_i (state_q == ST_FCS),
    .msb_o   (crc_msb)
  );

  assign run     = (state_q == ST_PRE) || (state_q == ST_DATA) || (state_q == ST_FCS);
  assign eod_now = eod_seen_q || tx_eod_i;
  assign load_o  = last_bit && (((state_q == ST_PRE) && (idx == IDX_SFD)) ||
                                ((state_q == ST_DATA) && !eod_now));
  assign byte_o  = last_bit && ((state_q == ST_DATA) || (state_q == ST_FCS));
  assign tx_en_o = run;
  assign eop_o   = (state_q == ST_END);
  assign txd_o   = run && ((state_q == ST_FCS) ? (crc_msb ^ !fcs_inv_q) : sh_q[0]);

  always_comb begin
    state_d    = state_q;
    sh_d       = sh_q;
    clr_idx    = 1'b0;
    fcs_en_d   = fcs_en_q;
    fcs_inv_d  = fcs_inv_q;
    eod_seen_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_req_i) begin
          state_d   = ST_PRE;
          sh_d      = PRE_BYTE;
          clr_idx   = 1'b1;
          fcs_en_d  = crc_en_i;
          fcs_inv_d = crc_inv_i;
        end
      end
      ST_PRE: begin
        sh_d = sh_q >> 1;
        if (last_bit) begin
          if (idx == IDX_SFD) begin
            sh_d    = tx_data_i;
            state_d = ST_DATA;
            clr_idx = 1'b1;
          end else if (idx == IDX_LPRE) begin
            sh_d = SFD_BYTE;
          end else begin
            sh_d = PRE_BYTE;
          end
        end
      end
      ST_DATA: begin
        sh_d       = sh_q >> 1;
        eod_seen_d = eod_now && !last_bit;
        if (last_bit) begin
          if (eod_now) begin
            state_d = fcs_en_q ? ST_FCS : ST_END;
            clr_idx = 1'b1;
          end else begin
            sh_d = tx_data_i;
          end
        end
      end
      ST_FCS: begin
        if (last_bit && (idx == IDX_LFCS)) state_d = ST_END;
      end
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      eod_seen_q <= 1'b0;
      fcs_en_q   <= 1'b0;
      fcs_inv_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      sh_q       <= sh_d;
      eod_seen_q <= eod_seen_d;
      fcs_en_q   <= fcs_en_d;
      fcs_inv_q  <= fcs_inv_d;
    end
  end
endmodule

// File: rtl/eth_tx_byte_seq_chk.sv
module eth_tx_byte_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_eod_i,
  input logic tx_en_o,
  input logic txd_o,
  input logic load_o,
  input logic byte_o,
  input logic eop_o
);
  logic [3:0] gap_q;
  logic       seen_load_q;
  logic       eod_flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q       <= '0;
      seen_load_q <= 1'b0;
      eod_flag_q  <= 1'b0;
    end else begin
      if (!tx_en_o) begin
        gap_q       <= '0;
        seen_load_q <= 1'b0;
        eod_flag_q  <= 1'b0;
      end else begin
        if (load_o)             gap_q <= '0;
        else if (gap_q != 4'hF) gap_q <= gap_q + 4'd1;
        if (load_o)                  seen_load_q <= 1'b1;
        if (tx_eod_i && seen_load_q) eod_flag_q  <= 1'b1;
      end
    end
  end

  p_load_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && seen_load_q) |-> (gap_q == 4'd7));

  p_no_load_after_eod_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eod_flag_q || (tx_eod_i && seen_load_q)) |-> !load_o);

  p_eop_at_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |-> (!tx_en_o && $past(tx_en_o)));

  p_fall_gives_eop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en_o) |-> eop_o);

  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_o |-> (!txd_o && !load_o && !byte_o));

  p_strobes_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_o && !byte_o, eop_o}));
endmodule

bind eth_tx_byte_seq eth_tx_byte_seq_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_eod_i (tx_eod_i),
  .tx_en_o  (tx_en_o),
  .txd_o    (txd_o),
  .load_o   (load_o),
  .byte_o   (byte_o),
  .eop_o    (eop_o)
);

// File: tb/test_eth_tx_byte_seq.sv
module test_eth_tx_byte_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_req_i, tx_eod_i, crc_en_i, crc_inv_i;
  logic [7:0] tx_data_i;
  logic       tx_en_o, txd_o, load_o, byte_o, eop_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] frame [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tx_byte_seq i_eth_tx_byte_seq (
    .clk(clk), .rst_n(rst_n), .tx_req_i(tx_req_i), .tx_data_i(tx_data_i),
    .tx_eod_i(tx_eod_i), .crc_en_i(crc_en_i), .crc_inv_i(crc_inv_i),
    .tx_en_o(tx_en_o), .txd_o(txd_o), .load_o(load_o), .byte_o(byte_o),
    .eop_o(eop_o)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int n, input bit inv);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'd0, frame[i]};
      for (int b = 0; b < 8; b++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return inv ? c : ~c;
  endfunction

  task automatic push_byte(ref bit q[$], input logic [7:0] v);
    for (int b = 0; b < 8; b++) q.push_back(v[b]);
  endtask

  // Runs one frame and checks R2..R12 on it; fcs_seen returns the last 32 line bits.
  task automatic run_frame(input string name, input int n, input bit ce, input bit ci,
                           input int eod_off, input bit poke, output logic [31:0] fcs_seen);
    bit got[$];
    bit exp[$];
    int loads = 0, last_load = -1, first_load_pos = -1, first_byte_pos = -1;
    int bytes = 0, eod_at = -1, eop_cyc = -1, eop_cnt = 0, fall_cyc = -1;
    bit bad_space = 0, extra_load = 0, rise_after = 0, noisy = 0;
    int mism = 0, mism_pre = 0;
    logic [31:0] f;
    @(negedge clk);
    crc_en_i = ce; crc_inv_i = ci; tx_req_i = 1'b1;
    @(negedge clk);
    tx_req_i = 1'b0;
    if (poke) begin crc_en_i = !ce; crc_inv_i = !ci; end
    for (int cyc = 0; cyc < 2000; cyc++) begin
      tx_eod_i = (cyc == eod_at);
      tx_req_i = poke && (cyc == 30 || cyc == 90);
      #1;
      if (tx_en_o) begin
        if (fall_cyc >= 0) rise_after = 1;
        got.push_back(txd_o);
      end else begin
        if (fall_cyc < 0) fall_cyc = cyc;
        if (txd_o || load_o || byte_o) noisy = 1;
      end
      if (load_o) begin
        if (loads == 0) first_load_pos = got.size() - 1;
        else if (cyc - last_load != 8) bad_space = 1;
        last_load = cyc;
        if (loads < n) begin
          tx_data_i = frame[loads];
          loads++;
          if (loads == n) eod_at = cyc + eod_off;
        end else extra_load = 1;
      end
      if (byte_o) begin
        bytes++;
        if (first_byte_pos < 0) first_byte_pos = got.size() - 1;
      end
      if (eop_o) begin eop_cnt++; if (eop_cyc < 0) eop_cyc = cyc; end
      if (eop_cyc >= 0 && cyc >= eop_cyc + 4) break;
      @(negedge clk);
    end
    tx_req_i = 1'b0; tx_eod_i = 1'b0;
    for (int i = 0; i < 7; i++) push_byte(exp, 8'h55);
    push_byte(exp, 8'hD5);
    for (int i = 0; i < n; i++) push_byte(exp, frame[i]);
    if (ce) begin
      f = ref_fcs(n, ci);
      for (int i = 0; i < 4; i++) push_byte(exp, f[8*i +: 8]);
    end
    for (int i = 0; i < 64 && i < got.size(); i++) if (got[i] != exp[i]) mism_pre++;
    for (int i = 0; i < exp.size() && i < got.size(); i++) if (got[i] != exp[i]) mism++;
    fcs_seen = '0;
    if (got.size() >= 32)
      for (int i = 0; i < 32; i++) fcs_seen[i] = got[got.size() - 32 + i];
    $display("scenario %s: %0d line bits", name, got.size());
    check("R2", mism_pre == 0 && got.size() >= 64, "preamble bit mismatches", mism_pre, 0);
    check("R3", first_load_pos == 63, "first load bit position", first_load_pos, 63);
    check("R4", !bad_space && loads == n, "loads given / spacing ok", loads, n);
    check("R5", !extra_load, "load after end-of-data", extra_load, 0);
    check(ce ? (ci ? "R7" : "R6") : "R8", got.size() == exp.size(), "frame length in bits",
          got.size(), exp.size());
    check(ce ? (ci ? "R7" : "R6") : "R8", mism == 0, "frame bit mismatches", mism, 0);
    check("R9", bytes == n + (ce ? 4 : 0), "byte pulses", bytes, n + (ce ? 4 : 0));
    check("R9", first_byte_pos == 71, "first byte pulse position", first_byte_pos, 71);
    check("R10", eop_cnt == 1 && eop_cyc == fall_cyc, "eop cycle", eop_cyc, fall_cyc);
    check("R12", !rise_after && !noisy, "tx_en gap or idle activity", rise_after, 0);
    if (poke) check("R11", eop_cnt == 1 && !rise_after, "eop count with mid-frame request",
                    eop_cnt, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tx_req_i = 0; tx_eod_i = 0; crc_en_i = 0; crc_inv_i = 0; tx_data_i = '0;
    repeat (3) @(negedge clk);
    check("R1", {tx_en_o, txd_o, load_o, byte_o, eop_o} == 5'b0, "outputs in reset",
          {tx_en_o, txd_o, load_o, byte_o, eop_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {tx_en_o, txd_o, load_o, byte_o, eop_o} == 5'b0, "outputs idle after reset",
          {tx_en_o, txd_o, load_o, byte_o, eop_o}, 0);
  endtask

  task automatic t_known_crc;
    logic [31:0] fs;
    for (int i = 0; i < 9; i++) frame[i] = 8'h31 + 8'(i);
    run_frame("known_crc", 9, 1'b1, 1'b0, 3, 1'b0, fs);
    check("R6", fs == 32'hCBF4_3926, "check value for 123456789", fs, 32'hCBF4_3926);
  endtask

  task automatic t_single_no_crc;
    logic [31:0] fs;
    frame[0] = 8'hA7;
    run_frame("single_no_crc", 1, 1'b0, 1'b0, 8, 1'b0, fs);
  endtask

  task automatic t_inverted;
    logic [31:0] fs;
    logic [31:0] good;
    for (int i = 0; i < 5; i++) frame[i] = 8'hF0 ^ 8'(i * 37);
    good = ref_fcs(5, 1'b0);
    run_frame("inverted", 5, 1'b1, 1'b1, 1, 1'b0, fs);
    check("R7", fs == ~good, "inverted check value", fs, ~good);
  endtask

  task automatic t_busy_request;
    logic [31:0] fs;
    for (int i = 0; i < 4; i++) frame[i] = 8'h0F << i;
    run_frame("busy_request", 4, 1'b1, 1'b0, 8, 1'b1, fs);
  endtask

  task automatic t_long;
    logic [31:0] fs;
    for (int i = 0; i < 16; i++) frame[i] = 8'(i * 29 + 3);
    run_frame("long", 16, 1'b1, 1'b0, 5, 1'b0, fs);
    repeat (5) @(negedge clk);
    check("R1", {tx_en_o, txd_o, load_o, byte_o, eop_o} == 5'b0, "idle after frames",
          {tx_en_o, txd_o, load_o, byte_o, eop_o}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_known_crc();
    t_single_no_crc();
    t_inverted();
    t_busy_request();
    t_long();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule